// File: doc/BRIEF.md
# General-Purpose I/O Port Register Bank

This block is a 32-line general-purpose I/O port. It sits behind a single-cycle memory-mapped register interface, with an address, a write strobe, write data and combinational read data. Each line connects to a pad through three signals: the value to drive, an output enable and the level sampled from the pad. Software sets each line to drive or to sense. Output lines can push-pull, or they can run as open-drain, where they pull low or let go. Input lines can be cut off from the data register.

Register bit positions run opposite to line numbers: line n is held in bit (31 - n) of every register. A data read returns the latched drive value for output lines. For input lines it returns the synchronised pad level, but only where the input-buffer enable is set. The output latch takes every bit of a data write whatever the direction, so a value can be preset before a line is turned into an output. Pad levels pass through a two-flop synchroniser before they reach the read path.

The design has no state machine. Its only sequential parts are the four configuration registers and the two synchroniser ranks, and each of them updates on every clock edge from a fixed rule.

Top module: `gpio_port_bank`

## Requirements
- R1: After reset the direction, open-drain, output latch and input-enable registers read 0, and every pad output enable is 0.
- R2: Register offsets are direction 0x00, open-drain select 0x04, data 0x08 and input-buffer enable 0x18. Any other offset reads 0, and a write to it changes no register.
- R3: Line n corresponds to bit (31 - n) of every register. Pad vectors are indexed by line number, so line 0 is register bit 31.
- R4: A direction bit of 1 makes the line an output and a direction bit of 0 makes it an input. A line that is not open-drain and is set as an output drives its latched value with its output enable at 1. An input line has its output enable at 0.
- R5: For an input line, the data bit shows the synchronised pad level when its input-buffer enable bit is 1, and reads 0 when that bit is 0.
- R6: A pad level change appears in a data read after exactly two rising clock edges.
- R7: For an output line, the data bit reads the latched value whatever the pad level.
- R8: For an output line with its open-drain bit set, a latched 0 gives output enable 1 with a driven 0, and a latched 1 gives output enable 0.
- R9: A data write loads all 32 latch bits whatever their direction. A line later switched to output drives the preset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 5 | Byte offset of the register accessed |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| pad_in | input | 32 | Pad levels, index = line number |
| pad_out | output | 32 | Value driven on each pad, index = line number |
| pad_oe | output | 32 | Output enable for each pad, index = line number |

## Verification
The assertions assume three things about the inputs. `addr`, `wr_en` and `wr_data` are steady around the rising edge. `pad_in` holds known values, so the synchroniser ranks never carry unknowns into the read path. A write strobe lasts a single cycle for each access. The bench changes every input on the falling edge only. It drives `pad_in` to defined values from reset onward. Its write task raises `wr_en` for exactly one rising edge.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int unsigned LINE_CNT = 32;
    localparam int unsigned OFS_W    = 5;

    localparam logic [OFS_W-1:0] OFS_DIR = 5'h00;
    localparam logic [OFS_W-1:0] OFS_ODS = 5'h04;
    localparam logic [OFS_W-1:0] OFS_DAT = 5'h08;
    localparam logic [OFS_W-1:0] OFS_IBE = 5'h18;

    typedef enum logic [2:0] {
        SEL_NONE = 3'd0,
        SEL_DIR  = 3'd1,
        SEL_ODS  = 3'd2,
        SEL_DAT  = 3'd3,
        SEL_IBE  = 3'd4
    } reg_sel_e;

    // Register bit b belongs to line (LINE_CNT-1-b).
    function automatic logic [LINE_CNT-1:0] line_swap(input logic [LINE_CNT-1:0] v);
        logic [LINE_CNT-1:0] r;
        for (int i = 0; i < LINE_CNT; i++) begin
            r[i] = v[LINE_CNT-1-i];
        end
        return r;
    endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int unsigned AW = OFS_W
) (
    input  logic [AW-1:0] addr,
    output reg_sel_e      sel
);

    always_comb begin
        unique case (addr)
            OFS_DIR: sel = SEL_DIR;
            OFS_ODS: sel = SEL_ODS;
            OFS_DAT: sel = SEL_DAT;
            OFS_IBE: sel = SEL_IBE;
            default: sel = SEL_NONE;
        endcase
    end

endmodule

// File: rtl/gpio_cfg_regs.sv
module gpio_cfg_regs
    import gpio_bank_pkg::*;
#(
    parameter int unsigned W = LINE_CNT
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  reg_sel_e     sel,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] dir_q,
    output logic [W-1:0] ods_q,
    output logic [W-1:0] dat_q,
    output logic [W-1:0] ibe_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            ods_q <= '0;
            dat_q <= '0;
            ibe_q <= '0;
        end else if (wr_en) begin
            unique case (sel)
                SEL_DIR:  dir_q <= wr_data;
                SEL_ODS:  ods_q <= wr_data;
                SEL_DAT:  dat_q <= wr_data;
                SEL_IBE:  ibe_q <= wr_data;
                SEL_NONE: ;
                default:  ;
            endcase
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw,
    output logic [W-1:0] mid,
    output logic [W-1:0] synced
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mid    <= '0;
            synced <= '0;
        end else begin
            mid    <= raw;
            synced <= mid;
        end
    end

endmodule

// File: rtl/gpio_pin_ctrl.sv
module gpio_pin_ctrl #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] ods_q,
    input  logic [W-1:0] dat_q,
    input  logic [W-1:0] ibe_q,
    input  logic [W-1:0] pad_sync,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] dat_view
);

    // n is the line number and b is its register bit.
    for (genvar n = 0; n < W; n++) begin : g_line
        localparam int unsigned B = W - 1 - n;
        always_comb begin
            pad_oe[n]   = dir_q[B] & ~(ods_q[B] & dat_q[B]);
            pad_out[n]  = dat_q[B] & ~ods_q[B];
            dat_view[B] = dir_q[B] ? dat_q[B] : (ibe_q[B] & pad_sync[n]);
        end
    end

endmodule

// File: rtl/gpio_port_bank.sv
module gpio_port_bank
    import gpio_bank_pkg::*;
#(
    parameter int unsigned W  = LINE_CNT,
    parameter int unsigned AW = OFS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic [W-1:0]  wr_data,
    output logic [W-1:0]  rd_data,
    input  logic [W-1:0]  pad_in,
    output logic [W-1:0]  pad_out,
    output logic [W-1:0]  pad_oe
);

    reg_sel_e     sel;
    logic [W-1:0] dir_q, ods_q, dat_q, ibe_q;
    logic [W-1:0] sync_mid, sync_q;
    logic [W-1:0] dat_view;

    gpio_addr_decode #(.AW(AW)) u_dec (
        .addr (addr),
        .sel  (sel)
    );

    gpio_cfg_regs #(.W(W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .sel     (sel),
        .wr_data (wr_data),
        .dir_q   (dir_q),
        .ods_q   (ods_q),
        .dat_q   (dat_q),
        .ibe_q   (ibe_q)
    );

    gpio_in_sync #(.W(W)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (pad_in),
        .mid    (sync_mid),
        .synced (sync_q)
    );

    gpio_pin_ctrl #(.W(W)) u_pins (
        .dir_q    (dir_q),
        .ods_q    (ods_q),
        .dat_q    (dat_q),
        .ibe_q    (ibe_q),
        .pad_sync (sync_q),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .dat_view (dat_view)
    );

    always_comb begin
        unique case (sel)
            SEL_DIR:  rd_data = dir_q;
            SEL_ODS:  rd_data = ods_q;
            SEL_DAT:  rd_data = dat_view;
            SEL_IBE:  rd_data = ibe_q;
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/gpio_port_bank_chk.sv
module gpio_port_bank_chk
    import gpio_bank_pkg::*;
#(
    parameter int unsigned W  = LINE_CNT,
    parameter int unsigned AW = OFS_W
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] addr,
    input logic          wr_en,
    input logic [W-1:0]  wr_data,
    input logic [W-1:0]  rd_data,
    input logic [W-1:0]  pad_out,
    input logic [W-1:0]  pad_oe,
    input logic [W-1:0]  dir_q,
    input logic [W-1:0]  ods_q,
    input logic [W-1:0]  dat_q,
    input logic [W-1:0]  ibe_q,
    input logic [W-1:0]  sync_mid,
    input logic [W-1:0]  sync_q
);

    logic known_ofs;
    assign known_ofs = (addr == OFS_DIR) || (addr == OFS_ODS) ||
                       (addr == OFS_DAT) || (addr == OFS_IBE);

    // R4: output enable only on lines whose direction bit selects output
    p_oe_dir_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & ~line_swap(dir_q)) == '0);

    // R8: an open-drain line that is enabled always drives low
    p_od_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_oe & pad_out & line_swap(ods_q)) == '0);

    // R6: second synchroniser rank follows the first one cycle later
    p_sync_two_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (sync_q == $past(sync_mid)));

    // R2: writes to unknown offsets leave all registers untouched
    p_write_ignored_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !known_ofs) |=>
            ($stable(dir_q) && $stable(ods_q) && $stable(dat_q) && $stable(ibe_q)));

    // R9: a data write loads every latch bit
    p_data_write_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_DAT) |=> (dat_q == $past(wr_data)));

    // R7: output lines read back the latch
    p_out_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == OFS_DAT) |-> ((rd_data & dir_q) == (dat_q & dir_q)));

    // R2: unknown offsets read zero
    p_unknown_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !known_ofs |-> (rd_data == '0));

endmodule

bind gpio_port_bank gpio_port_bank_chk #(.W(W), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .rd_data  (rd_data),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .dir_q    (dir_q),
    .ods_q    (ods_q),
    .dat_q    (dat_q),
    .ibe_q    (ibe_q),
    .sync_mid (sync_mid),
    .sync_q   (sync_q)
);

// File: tb/tb_gpio_port_bank.sv
module tb_gpio_port_bank;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port_bank dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .rd_data (rd_data),
        .pad_in  (pad_in),
        .pad_out (pad_out),
        .pad_oe  (pad_oe)
    );

    function automatic logic [31:0] flip(input logic [31:0] v);
        logic [31:0] r;
        for (int i = 0; i < 32; i++) r[i] = v[31-i];
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wr_data = d; wr_en = 1'b1;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        addr = a;
        #1 d = rd_data;
    endtask

    task automatic settle();
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(5'h00, v); check("R1 dir", v, 32'h0);
        rd(5'h04, v); check("R1 ods", v, 32'h0);
        rd(5'h08, v); check("R1 dat", v, 32'h0);
        rd(5'h18, v); check("R1 ibe", v, 32'h0);
        check("R1 oe", pad_oe, 32'h0);
    endtask

    task automatic t_offsets();
        logic [31:0] v;
        wr(5'h04, 32'hA5A5_A5A5);
        rd(5'h04, v); check("R2 ods readback", v, 32'hA5A5_A5A5);
        wr(5'h18, 32'h1234_5678);
        rd(5'h18, v); check("R2 ibe readback", v, 32'h1234_5678);
        wr(5'h0C, 32'hFFFF_FFFF);
        rd(5'h0C, v); check("R2 unknown read", v, 32'h0);
        rd(5'h00, v); check("R2 dir untouched", v, 32'h0);
        rd(5'h04, v); check("R2 ods untouched", v, 32'hA5A5_A5A5);
        rd(5'h18, v); check("R2 ibe untouched", v, 32'h1234_5678);
        wr(5'h04, 32'h0);
        wr(5'h18, 32'h0);
    endtask

    task automatic t_bit_order();
        wr(5'h08, 32'h8000_0000);
        wr(5'h00, 32'h8000_0000);
        @(negedge clk);
        check("R3 line0 oe", pad_oe, 32'h0000_0001);
        check("R4 line0 drives 1", pad_out & pad_oe, 32'h0000_0001);
        wr(5'h00, 32'h0);
        wr(5'h08, 32'h0);
    endtask

    task automatic t_preset();
        wr(5'h08, 32'hFFFF_0000);
        @(negedge clk);
        check("R9 inputs stay off", pad_oe, 32'h0);
        wr(5'h00, 32'hFFFF_FFFF);
        @(negedge clk);
        check("R4 all outputs on", pad_oe, 32'hFFFF_FFFF);
        check("R9 preset driven", pad_out, 32'h0000_FFFF);
        wr(5'h00, 32'h0);
        wr(5'h08, 32'h0);
    endtask

    task automatic t_input_gate();
        logic [31:0] v;
        @(negedge clk); pad_in = 32'hFFFF_FFFF;
        settle();
        rd(5'h08, v); check("R5 gated off", v, 32'h0);
        wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h08, v); check("R5 gated on", v, 32'hFFFF_FFFF);
        @(negedge clk); pad_in = 32'h0000_0001;
        settle();
        rd(5'h08, v); check("R3 line0 input at bit31", v, 32'h8000_0000);
        wr(5'h18, 32'h0000_FFFF);
        @(negedge clk); pad_in = 32'hFFFF_FFFF;
        settle();
        rd(5'h08, v); check("R5 partial enable", v, 32'h0000_FFFF);
        wr(5'h18, 32'hFFFF_FFFF);
    endtask

    task automatic t_sync_latency();
        logic [31:0] v;
        @(negedge clk); pad_in = 32'h0; addr = 5'h08;
        settle();
        pad_in = 32'h0F0F_0F0F;
        @(negedge clk); #1 v = rd_data;
        check("R6 after one edge", v, 32'h0);
        @(negedge clk); #1 v = rd_data;
        check("R6 after two edges", v, flip(32'h0F0F_0F0F));
    endtask

    task automatic t_out_readback();
        logic [31:0] v;
        wr(5'h00, 32'hFFFF_0000);
        wr(5'h08, 32'hAAAA_5555);
        @(negedge clk); pad_in = 32'h0;
        settle();
        rd(5'h08, v); check("R7 pads low", v, 32'hAAAA_0000);
        @(negedge clk); pad_in = 32'hFFFF_FFFF;
        settle();
        rd(5'h08, v); check("R7 pads high", v, 32'hAAAA_FFFF);
        wr(5'h00, 32'h0);
    endtask

    task automatic t_open_drain();
        wr(5'h00, 32'hFFFF_FFFF);
        wr(5'h04, 32'hFFFF_FFFF);
        wr(5'h08, 32'h0000_FFFF);
        @(negedge clk);
        check("R8 od oe", pad_oe, 32'h0000_FFFF);
        check("R8 od drives low", pad_out & pad_oe, 32'h0);
        wr(5'h04, 32'h0);
        @(negedge clk);
        check("R4 push-pull oe", pad_oe, 32'hFFFF_FFFF);
        check("R4 push-pull value", pad_out, 32'hFFFF_0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_offsets();
        t_bit_order();
        t_preset();
        t_input_gate();
        t_sync_latency();
        t_out_readback();
        t_open_drain();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule